// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block adds or subtracts two operands at a byte, word or doubleword width and produces the status flags of a conventional flag-based processor. These are carry (a borrow on subtract), even parity of the low byte, a nibble carry between bit 3 and bit 4, zero, sign and signed overflow. One lane exists for each operand width. The size select chooses which lane's outputs are kept.

A single-cycle update strobe captures the result and the flags into a register. The stored carry flag feeds back as the carry-in for add-with-carry and as the borrow-in for subtract-with-borrow. The registered outputs appear on the clock edge after the strobe. They hold their values until the next strobe or a reset.

Top module: `arith_flag_unit`

## Requirements
- R1: A synchronous active-high reset clears the result and all six flags to zero.
- R2: Result and flags change only on a clock edge where `upd_i` is high. The new values are visible from that edge onward and are held while `upd_i` stays low.
- R3: The operation codes on `op_i` are 00 add, 01 add with carry, 10 subtract and 11 subtract with borrow. The incoming carry or borrow is the stored carry flag. The result wraps modulo 2^n, where n is the selected width.
- R4: The size codes on `size_i` are 00 for 8 bits, 01 for 16 bits, and 10 or 11 for 32 bits. Operand bits above the selected width are ignored, and result bits above it read as zero.
- R5: On add, the carry flag is the carry out of bit n-1. On subtract, it is set when the first operand is smaller than the second operand plus the borrow-in.
- R6: The parity flag is 1 when the low 8 bits of the result hold an even number of ones.
- R7: The auxiliary flag is the carry or borrow passed from bit 3 into bit 4.
- R8: The zero flag is 1 when the n-bit result is all zeros.
- R9: The sign flag equals result bit n-1.
- R10: On add, the overflow flag is set when both operands have the same sign and the result's sign differs from it. On subtract, it is set when the operand signs differ and the result's sign differs from the first operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_i | input | 1 | Update strobe: capture result and flags |
| op_i | input | 2 | Operation code |
| size_i | input | 2 | Operand width code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Registered result, zero above the selected width |
| cf_o | output | 1 | Carry / borrow flag |
| pf_o | output | 1 | Even parity of result low byte |
| af_o | output | 1 | Carry / borrow from bit 3 into bit 4 |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Signed overflow flag |

## Verification
The bench builds the unit with its default parameters: three width lanes and a 32-bit datapath. With these defaults, a single instance can exercise the byte, word and doubleword lanes, including the reserved size code that aliases to 32 bits. Directed vectors cover carries into and out of the top bit, nibble borrows, and signed overflow in both directions. Garbage placed above the selected width shows that those bits are ignored. Chained add-with-carry and subtract-with-borrow operations exercise the stored-carry feedback. A long random run at all three widths, with the strobe sometimes low, checks every flag against a model in the bench.

// File: rtl/afg_pkg.sv
package afg_pkg;
  localparam int NUM_SIZES = 3;
  localparam int DATA_W    = 8 << (NUM_SIZES - 1);
  localparam int SEL_W     = $clog2(NUM_SIZES);

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_ADC = 2'b01,
    OP_SUB = 2'b10,
    OP_SBB = 2'b11
  } op_e;

  typedef struct packed {
    logic of_f;
    logic sf_f;
    logic zf_f;
    logic af_f;
    logic pf_f;
    logic cf_f;
  } flags_t;
endpackage

// File: rtl/afg_lane.sv
module afg_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cf,
  output logic         af,
  output logic         of
);
  logic [W:0] full;

  always_comb begin
    if (sub) full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
    else     full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    res = full[W-1:0];
    cf  = full[W];
    af  = a[4] ^ b[4] ^ full[4];
    if (sub) of = (a[W-1] ^ b[W-1]) & (full[W-1] ^ a[W-1]);
    else     of = ~(a[W-1] ^ b[W-1]) & (full[W-1] ^ a[W-1]);
  end
endmodule

// File: rtl/afg_flag_eval.sv
module afg_flag_eval
  import afg_pkg::*;
(
  input  logic [DATA_W-1:0] res,
  input  logic [SEL_W-1:0]  sel,
  output logic              pf,
  output logic              zf,
  output logic              sf
);
  always_comb begin
    pf = ~^res[7:0];
    zf = (res == '0);
    sf = res[DATA_W-1];
    for (int i = 0; i < NUM_SIZES; i++) begin
      if (sel == SEL_W'(i)) sf = res[(8 << i) - 1];
    end
  end
endmodule

// File: rtl/afg_flag_reg.sv
module afg_flag_reg
  import afg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [DATA_W-1:0] res_d,
  input  flags_t            flg_d,
  output logic [DATA_W-1:0] res_q,
  output flags_t            flg_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      flg_q <= '0;
    end else if (upd) begin
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  logic seen_q = 1'b0;
  always_ff @(posedge clk) if (rst) seen_q <= 1'b1;

  assert_rst_clear_R1: assert property (@(posedge clk) disable iff (rst)
    seen_q && $past(rst) |-> (res_q == '0) && (flg_q == '0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    seen_q && !$past(rst) && !$past(upd) |-> $stable(res_q) && $stable(flg_q));
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import afg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        upd_i,
  input  logic [1:0]  op_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] a_i,
  input  logic [31:0] b_i,
  output logic [31:0] result_o,
  output logic        cf_o,
  output logic        pf_o,
  output logic        af_o,
  output logic        zf_o,
  output logic        sf_o,
  output logic        of_o
);
  flags_t            flg_q, flg_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic [SEL_W-1:0]  sel;
  logic              use_cin, is_sub;

  logic [DATA_W-1:0] lane_res [NUM_SIZES];
  logic              lane_cf  [NUM_SIZES];
  logic              lane_af  [NUM_SIZES];
  logic              lane_of  [NUM_SIZES];

  assign is_sub  = (op_i == OP_SUB) || (op_i == OP_SBB);
  assign use_cin = ((op_i == OP_ADC) || (op_i == OP_SBB)) & flg_q.cf_f;

  always_comb begin
    sel = SEL_W'(NUM_SIZES - 1);
    if (size_i < 2'(NUM_SIZES - 1)) sel = SEL_W'(size_i);
  end

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
    localparam int LW = 8 << g;
    logic [LW-1:0] r;
    afg_lane #(.W(LW)) lane_i (
      .a   (a_i[LW-1:0]),
      .b   (b_i[LW-1:0]),
      .sub (is_sub),
      .cin (use_cin),
      .res (r),
      .cf  (lane_cf[g]),
      .af  (lane_af[g]),
      .of  (lane_of[g])
    );
    assign lane_res[g] = DATA_W'(r);
  end

  logic pf_c, zf_c, sf_c;

  always_comb begin
    res_d       = lane_res[NUM_SIZES-1];
    flg_d       = '0;
    flg_d.cf_f  = lane_cf[NUM_SIZES-1];
    flg_d.af_f  = lane_af[NUM_SIZES-1];
    flg_d.of_f  = lane_of[NUM_SIZES-1];
    for (int i = 0; i < NUM_SIZES; i++) begin
      if (sel == SEL_W'(i)) begin
        res_d      = lane_res[i];
        flg_d.cf_f = lane_cf[i];
        flg_d.af_f = lane_af[i];
        flg_d.of_f = lane_of[i];
      end
    end
    flg_d.pf_f = pf_c;
    flg_d.zf_f = zf_c;
    flg_d.sf_f = sf_c;
  end

  afg_flag_eval eval_i (
    .res (res_d),
    .sel (sel),
    .pf  (pf_c),
    .zf  (zf_c),
    .sf  (sf_c)
  );

  afg_flag_reg reg_i (
    .clk   (clk),
    .rst   (rst),
    .upd   (upd_i),
    .res_d (res_d),
    .flg_d (flg_d),
    .res_q (res_q),
    .flg_q (flg_q)
  );

  assign result_o = res_q;
  assign cf_o     = flg_q.cf_f;
  assign pf_o     = flg_q.pf_f;
  assign af_o     = flg_q.af_f;
  assign zf_o     = flg_q.zf_f;
  assign sf_o     = flg_q.sf_f;
  assign of_o     = flg_q.of_f;

  logic             upd_seen_q = 1'b0;
  logic [1:0]       size_q     = 2'b00;
  always_ff @(posedge clk) begin
    if (rst) upd_seen_q <= 1'b0;
    else if (upd_i) begin
      upd_seen_q <= 1'b1;
      size_q     <= size_i;
    end
  end

  assert_byte_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    upd_seen_q && (size_q == 2'b00) |-> (result_o[31:8] == '0));

  assert_word_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    upd_seen_q && (size_q == 2'b01) |-> (result_o[31:16] == '0));

  assert_parity_R6: assert property (@(posedge clk) disable iff (rst)
    upd_seen_q |-> (pf_o == ($countones(result_o[7:0]) % 2 == 0)));

  assert_zero_R8: assert property (@(posedge clk) disable iff (rst)
    upd_seen_q |-> (zf_o == (result_o == 32'd0)));

  assert_sign_R9: assert property (@(posedge clk) disable iff (rst)
    upd_seen_q |-> (sf_o == ((size_q == 2'b00) ? result_o[7] :
                             (size_q == 2'b01) ? result_o[15] : result_o[31])));

  assert_zero_sign_R8: assert property (@(posedge clk) disable iff (rst)
    upd_seen_q && zf_o |-> !sf_o);
endmodule

// File: tb/arith_flag_unit_tb_top.sv
module arith_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        upd_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [1:0]  size_i = 2'b00;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [31:0] result_o;
  logic        cf_o, pf_o, af_o, zf_o, sf_o, of_o;

  always #2 clk = ~clk;

  arith_flag_unit dut_i (
    .clk(clk), .rst(rst), .upd_i(upd_i), .op_i(op_i), .size_i(size_i),
    .a_i(a_i), .b_i(b_i), .result_o(result_o),
    .cf_o(cf_o), .pf_o(pf_o), .af_o(af_o), .zf_o(zf_o), .sf_o(sf_o), .of_o(of_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic model_cf = 1'b0;

  // vector: op, size, a, b, expected result, expected flags {of,sf,zf,af,pf,cf}
  localparam int NV = 7;
  localparam logic [105:0] VEC [NV] = '{
    {2'b00, 2'b00, 32'h0000_00FF, 32'h0000_0001, 32'h0000_0000, 6'b001111},
    {2'b00, 2'b00, 32'h0000_007F, 32'h0000_0001, 32'h0000_0080, 6'b110100},
    {2'b10, 2'b01, 32'h0000_0000, 32'h0000_0001, 32'h0000_FFFF, 6'b010111},
    {2'b10, 2'b10, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 6'b100110},
    {2'b00, 2'b01, 32'hABCD_1234, 32'h1234_0001, 32'h0000_1235, 6'b000010},
    {2'b00, 2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 6'b010101},
    {2'b10, 2'b00, 32'h1111_1105, 32'h2222_2205, 32'h0000_0000, 6'b001010}
  };

  function automatic logic [37:0] ref_op(input logic [1:0] op, input logic [1:0] sz,
                                         input logic [31:0] a, input logic [31:0] b,
                                         input logic cin_st);
    int n;
    logic [63:0] mask, am, bm, full;
    logic [31:0] r;
    logic cin, cf, af, of, zf, sf, pf;
    n    = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    mask = (64'd1 << n) - 64'd1;
    am   = {32'd0, a} & mask;
    bm   = {32'd0, b} & mask;
    cin  = op[0] & cin_st;
    if (op[1]) full = am - bm - {63'd0, cin};
    else       full = am + bm + {63'd0, cin};
    cf = full[n];
    r  = full[31:0] & mask[31:0];
    af = am[4] ^ bm[4] ^ r[4];
    if (op[1]) of = (am[n-1] != bm[n-1]) && (r[n-1] != am[n-1]);
    else       of = (am[n-1] == bm[n-1]) && (r[n-1] != am[n-1]);
    zf = (r == 32'd0);
    sf = r[n-1];
    pf = ($countones(r[7:0]) % 2 == 0);
    return {r, of, sf, zf, af, pf, cf};
  endfunction

  task automatic check(input string req, input logic [31:0] er, input logic [5:0] ef);
    logic [5:0] af_now;
    af_now = {of_o, sf_o, zf_o, af_o, pf_o, cf_o};
    n_chk++;
    if (result_o !== er || af_now !== ef) begin
      n_bad++;
      $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
               req, result_o, af_now, er, ef);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [1:0] sz,
                       input logic [31:0] a, input logic [31:0] b, input logic u);
    @(negedge clk);
    op_i = op; size_i = sz; a_i = a; b_i = b; upd_i = u;
    @(posedge clk);
    #1 upd_i = 1'b0;
    @(negedge clk);
  endtask

  logic [37:0] exp_v;
  logic [31:0] keep_r;
  logic [5:0]  keep_f;
  bit          done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset state", 32'd0, 6'd0);

    // table walk: R5 R6 R7 R8 R9 R10 R4
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][105:104], VEC[i][103:102], VEC[i][101:70], VEC[i][69:38], 1'b1);
      check($sformatf("R5/R6/R7/R8/R9/R10/R4 vector %0d", i), VEC[i][37:6], VEC[i][5:0]);
    end

    // R3 add with carry: FF+01 sets CF, then 10+20+1 = 31
    apply(2'b00, 2'b00, 32'hFF, 32'h01, 1'b1);
    apply(2'b01, 2'b00, 32'h10, 32'h20, 1'b1);
    check("R3 adc uses stored carry", 32'h31, 6'b000000);
    // R3 add with carry ignores carry when CF clear: 10+20 = 30
    apply(2'b01, 2'b00, 32'h10, 32'h20, 1'b1);
    check("R3 adc with clear carry", 32'h30, 6'b000010);
    // R3 subtract with borrow: 0-1 sets CF, then 10-05-1 = 0A
    apply(2'b10, 2'b00, 32'h00, 32'h01, 1'b1);
    apply(2'b11, 2'b00, 32'h10, 32'h05, 1'b1);
    check("R3 sbb uses stored borrow", 32'h0A, 6'b000110);

    // R2 hold when strobe low
    apply(2'b00, 2'b10, 32'h1234_5678, 32'h1111_1111, 1'b0);
    check("R2 hold without strobe", 32'h0A, 6'b000110);

    // random reference comparison across all sizes
    model_cf = cf_o;
    keep_r = result_o;
    keep_f = {of_o, sf_o, zf_o, af_o, pf_o, cf_o};
    for (int k = 0; k < 600; k++) begin
      logic [1:0] op, sz;
      logic [31:0] a, b;
      logic u;
      op = 2'($urandom); sz = 2'($urandom);
      a = $urandom; b = $urandom;
      if (k % 5 == 0) begin a = a & 32'h8000_000F; b = b & 32'h8000_000F; end
      u = ($urandom % 8) != 0;
      apply(op, sz, a, b, u);
      if (u) begin
        exp_v = ref_op(op, sz, a, b, model_cf);
        keep_r = exp_v[37:6];
        keep_f = exp_v[5:0];
        model_cf = exp_v[0];
      end
      check(u ? "R3/R5/R6/R7/R8/R9/R10 random" : "R2 random hold", keep_r, keep_f);
    end

    // R1 mid-run reset
    apply(2'b00, 2'b00, 32'h7F, 32'h7F, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset after activity", 32'd0, 6'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule